// File: doc/BRIEF.md
# Latency-Insensitive Relay Station

The relay station is a storage element dropped into a long point-to-point channel so that a wire whose delay exceeds the clock period can be cut into one-cycle segments. Each cycle the channel carries a packet made of a payload bus and a one-bit void flag. The stop flag runs the other way and pushes back on the sender. The station forwards true packets with one cycle of delay. It keeps their order, loses none of them, and may only change where void packets sit between them.

The stop flag sent upstream comes from a register. It therefore reaches the sender one cycle after the station decides to stall. In that cycle the sender may still hand over one more packet. A main register and an auxiliary register absorb that packet. A four-state controller (processing, writing the auxiliary register, stalling, reading the auxiliary register) decides which of the two registers captures input and which one feeds the output.

Top module: `relay_station`

## Requirements
- R1: While rst_ni is low and just after it rises, out_void_o is 1 and in_stop_o is 0. No packet is stored.
- R2: A true packet is taken in on a rising clock edge when in_void_i is 0 and in_stop_o is 1'b0. It appears at the output from the next cycle on, never in the cycle it is presented. No input has a combinational path to out_void_o or out_data_o.
- R3: In a cycle where out_void_o is 0 and out_stop_i is 1, the station presents the same packet again in the following cycle, with out_void_o 0 and out_data_o unchanged.
- R4: At most two true packets are held at any time, meaning taken in but not yet delivered. A delivered packet is one shown with out_void_o 0 while out_stop_i is 0. No packet that was taken in is lost.
- R5: in_stop_o is a registered output. A change on out_stop_i reaches it no earlier than one clock edge later. in_stop_o only rises after a cycle in which out_stop_i was 1.
- R6: With out_stop_i held at 0 and a true packet offered every cycle, the station delivers one true packet every cycle.
- R7: True packets leave in exactly the order they were taken in.
- R8: in_stop_o is 1 in exactly those cycles in which two true packets are held.
- R9: While in_stop_o is 1, the input packet is ignored. A true packet offered then is not taken in and must be offered again by the sender.
- R10: A packet with in_void_i equal to 1 is never stored. Its payload has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | DATA_W | Payload from the upstream segment |
| in_void_i | input | 1 | 1 when the upstream packet carries no data |
| in_stop_o | output | 1 | Registered back-pressure to the upstream sender |
| out_data_o | output | DATA_W | Payload to the downstream segment, don't-care while void |
| out_void_o | output | 1 | 1 when the output packet carries no data |
| out_stop_i | input | 1 | Back-pressure from the downstream receiver |

## Verification
The main sweep tries every pairing of a 4-cycle stop pattern with a 4-cycle void pattern. This separates single-cycle stalls, stalls that start while a packet arrives, stalls that last long enough to use the auxiliary register and then stall further, and releases that land just as new input appears. A plain stream with no stalls isolates the one-per-cycle rate. A long pseudo-random run then mixes stalls and gaps of all lengths. A reset applied while both registers are full shows that the occupancy restarts from zero. Every cycle, the outputs and the upstream stop are compared against a two-entry queue held in the bench, and the sequence numbers of the delivered packets expose any loss, duplication or reordering.

// File: rtl/relay_pkg.sv
package relay_pkg;
  typedef enum logic [1:0] {
    RS_PROC  = 2'd0,
    RS_WAUX  = 2'd1,
    RS_STALL = 2'd2,
    RS_RAUX  = 2'd3
  } relay_state_e;
endpackage

// File: rtl/relay_slot.sv
module relay_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= valid_i;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/relay_ctrl.sv
module relay_ctrl
  import relay_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic main_valid_i,
  input  logic in_true_i,
  input  logic out_stop_i,
  output logic main_load_o,
  output logic main_from_aux_o,
  output logic aux_load_o,
  output logic aux_valid_o,
  output logic up_stop_o
);
  relay_state_e state_q, state_d;
  logic held;

  assign held = main_valid_i & out_stop_i;

  always_comb begin
    state_d         = state_q;
    main_load_o     = 1'b0;
    main_from_aux_o = 1'b0;
    aux_load_o      = 1'b0;
    aux_valid_o     = 1'b0;
    unique case (state_q)
      RS_PROC, RS_RAUX: begin
        if (held) begin
          // last packet slipping past the registered stop lands in aux
          if (in_true_i) begin
            aux_load_o  = 1'b1;
            aux_valid_o = 1'b1;
            state_d     = RS_WAUX;
          end else begin
            state_d = RS_PROC;
          end
        end else begin
          main_load_o = 1'b1;
          state_d     = RS_PROC;
        end
      end
      RS_WAUX, RS_STALL: begin
        if (out_stop_i) begin
          state_d = RS_STALL;
        end else begin
          main_load_o     = 1'b1;
          main_from_aux_o = 1'b1;
          aux_load_o      = 1'b1;
          aux_valid_o     = 1'b0;
          state_d         = RS_RAUX;
        end
      end
      default: state_d = RS_PROC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RS_PROC;
    else         state_q <= state_d;
  end

  assign up_stop_o = (state_q == RS_WAUX) || (state_q == RS_STALL);
endmodule

// File: rtl/relay_station.sv
module relay_station #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_void_i,
  output logic              in_stop_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_void_o,
  input  logic              out_stop_i
);
  logic              main_valid, aux_valid;
  logic [DATA_W-1:0] main_data, aux_data;
  logic              main_load, main_from_aux, aux_load, aux_valid_set;
  logic [DATA_W-1:0] main_next_data;
  logic              main_next_valid;

  relay_ctrl ctrl_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .main_valid_i   (main_valid),
    .in_true_i      (~in_void_i),
    .out_stop_i     (out_stop_i),
    .main_load_o    (main_load),
    .main_from_aux_o(main_from_aux),
    .aux_load_o     (aux_load),
    .aux_valid_o    (aux_valid_set),
    .up_stop_o      (in_stop_o)
  );

  assign main_next_data  = main_from_aux ? aux_data : in_data_i;
  assign main_next_valid = main_from_aux ? aux_valid : ~in_void_i;

  relay_slot #(.DATA_W(DATA_W)) main_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (main_load),
    .valid_i(main_next_valid),
    .data_i (main_next_data),
    .valid_o(main_valid),
    .data_o (main_data)
  );

  relay_slot #(.DATA_W(DATA_W)) aux_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (aux_load),
    .valid_i(aux_valid_set),
    .data_i (in_data_i),
    .valid_o(aux_valid),
    .data_o (aux_data)
  );

  assign out_data_o = main_data;
  assign out_void_o = ~main_valid;
endmodule

// File: rtl/relay_station_chk.sv
module relay_station_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_void_i,
  input logic              in_stop_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_void_o,
  input logic              out_stop_i
);
  logic [2:0] occ_q;
  logic       acc, dlv;

  assign acc = ~in_void_i & ~in_stop_o;
  assign dlv = ~out_void_o & ~out_stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= 3'd0;
    else         occ_q <= occ_q + {2'b0, acc} - {2'b0, dlv};
  end

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_void_o && out_stop_i) |=> (!out_void_o && $stable(out_data_o)));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= 3'd2);

  assert_stop_after_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_stop_o) |-> $past(out_stop_i));

  assert_stop_when_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_stop_o == (occ_q == 3'd2));

  assert_fwd_origin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_void_o) |-> $past(!in_void_i && !in_stop_o));

  assert_void_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_void_o == (occ_q == 3'd0));
endmodule

bind relay_station relay_station_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_void_i (in_void_i),
  .in_stop_o (in_stop_o),
  .out_data_o(out_data_o),
  .out_void_o(out_void_o),
  .out_stop_i(out_stop_i)
);

// File: tb/relay_station_tb_top.sv
`timescale 1ns/1ps
module relay_station_tb_top;
  localparam int unsigned DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          in_void_i = 1'b1;
  logic          in_stop_o;
  logic [DW-1:0] out_data_o;
  logic          out_void_o;
  logic          out_stop_i = 1'b0;

  relay_station #(.DATA_W(DW)) dut_i (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0, cycles = 0;
  logic [DW-1:0] mq[2];
  int mocc = 0;
  logic [DW-1:0] src_seq = '0, exp_seq = '0, cur = '0;
  bit pending = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  // one channel cycle against the two-entry queue model
  task automatic step(input bit stop, input bit want_void, input bit stream_chk);
    bit acc, dlv, pre_stop, pre_void;
    logic [DW-1:0] pre_data;
    @(negedge clk_i);
    chk(out_void_o == (mocc == 0), "R2 R10 out_void", out_void_o, mocc == 0);
    if (mocc != 0) chk(out_data_o == mq[0], "R7 out_data", out_data_o, mq[0]);
    chk(in_stop_o == (mocc == 2), "R8 in_stop", in_stop_o, mocc == 2);
    if (stream_chk) chk(out_void_o == 1'b0, "R6 rate", out_void_o, 0);
    pre_stop = in_stop_o; pre_void = out_void_o; pre_data = out_data_o;
    if (!pending && !want_void) begin
      cur = src_seq; src_seq++; pending = 1;
    end
    in_void_i  = !pending;
    in_data_i  = pending ? cur : (8'hA5 ^ DW'(cycles * 37));
    out_stop_i = stop;
    #1;
    chk(in_stop_o == pre_stop, "R5 comb stop", in_stop_o, pre_stop);
    chk(out_void_o == pre_void && out_data_o == pre_data, "R2 comb out", out_data_o, pre_data);
    acc = pending && !in_stop_o;
    dlv = !out_void_o && !stop;
    if (dlv) begin
      chk(out_data_o == exp_seq, "R7 R4 order", out_data_o, exp_seq);
      exp_seq++;
    end
    @(posedge clk_i);
    if (dlv) begin mq[0] = mq[1]; mocc--; end
    if (acc) begin mq[mocc] = cur; mocc++; pending = 0; end
    chk(mocc <= 2, "R4 capacity", mocc, 2);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; in_void_i = 1'b1; out_stop_i = 1'b0;
    #1;
    chk(out_void_o == 1'b1, "R1 void in reset", out_void_o, 1);
    chk(in_stop_o == 1'b0, "R1 stop in reset", in_stop_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mocc = 0; pending = 0; exp_seq = src_seq;
    @(negedge clk_i);
    chk(out_void_o == 1'b1, "R1 void after reset", out_void_o, 1);
    chk(in_stop_o == 1'b0, "R1 stop after reset", in_stop_o, 0);
  endtask

  initial begin
    do_reset();
    // R6: plain stream, no stalls
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, i > 0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
    // R9: long stall while sender keeps offering
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0);
    // R3 R8 sweep over every 4-cycle stop and void pattern
    for (int sp = 0; sp < 16; sp++)
      for (int vp = 0; vp < 16; vp++)
        for (int c = 0; c < 16; c++)
          step(sp[c % 4], vp[(c / 4 + c) % 4], 1'b0);
    // pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3], lfsr[5] & ~lfsr[7], 1'b0);
    end
    // R1: reset while full
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
    chk(in_stop_o == 1'b1 || mocc == 2, "R8 full before reset", in_stop_o, 1);
    do_reset();
    for (int i = 0; i < 20; i++) step(i[1], 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0);
    chk(mocc == 0 && exp_seq == src_seq, "R4 all delivered", exp_seq, src_seq);
    summary();
  end
endmodule